// File: doc/BRIEF.md
# Load Fault Drain Controller

This block sits beside the lane result queues of a vector load path. It steps in when address generation reports an illegal access partway through a load. Beats that already reached the lane queues are valid data that belong to elements before the fault. They must reach the register file before the fault is reported, so that the instruction can later be restarted from the faulting element without losing or repeating work.

When a fault is sampled, the controller records which lanes hold buffered data and the current vstart value. It then blocks new memory beats and asks every recorded lane to drain its queue. It waits until each of those lanes has returned a final grant. Only then does it issue a single-cycle exception response that carries the recorded vstart.

A separate flag stays set from the fault until the next burst begins, which marks the interrupted burst for replay. A flush abandons all of this work at once and returns the controller to idle.

Top module: `ld_fault_drain`

## Requirements
- R1: While reset is held, and on the first cycle after it, `beat_block_o`, `exc_valid_o` and `burst_exc_o` are low and `drain_req_o` is zero.
- R2: A fault sampled in idle while any bit of `q_occ_i` is set makes `drain_req_o` equal that occupancy snapshot on the next cycle. On that same cycle `beat_block_o` and `burst_exc_o` are high and `exc_valid_o` is low.
- R3: A fault sampled in idle while `q_occ_i` is zero raises `exc_valid_o` on the very next cycle, with `drain_req_o` zero.
- R4: Bit i of `drain_req_o` clears on the cycle after `lane_gnt_i[i]` is sampled high. `exc_valid_o` rises one cycle after the edge at which no requested lane remains ungranted. That edge is never earlier than the second edge after the fault, and `drain_req_o` is zero while `exc_valid_o` is high.
- R5: `exc_valid_o` is high for exactly one cycle, after which the controller is idle (`beat_block_o` low).
- R6: During the exception response, `exc_vstart_o` equals the `vstart_i` value sampled with the fault. Later changes of `vstart_i` do not alter it.
- R7: `beat_block_o` is high from the cycle after the fault up to and including the exception response cycle, and low on the cycle after it.
- R8: `burst_exc_o` sets with the fault and stays set after the response. It clears on the cycle after `burst_start_i` is sampled in idle. `burst_start_i` is ignored while a drain or response is in progress.
- R9: `flush_i` sampled in any state makes the next cycle idle: `beat_block_o`, `exc_valid_o` and `burst_exc_o` are low, `drain_req_o` is zero, and no exception response follows.
- R10: When `flush_i` and `fault_i` are sampled together in idle, the flush wins and no drain or response starts.
- R11: `fault_i` is ignored outside idle: it produces neither a second response nor a new vstart capture.
- R12: Changes of `q_occ_i` during a drain add no lanes to `drain_req_o`, and a grant on a lane that was not requested has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Abandon the current operation |
| fault_i | input | 1 | Illegal access reported by address generation |
| burst_start_i | input | 1 | A new burst begins (clears the replay flag in idle) |
| vstart_i | input | VW | Current vstart value |
| q_occ_i | input | NL | Per-lane result queue holds data |
| lane_gnt_i | input | NL | Per-lane final grant from the register file |
| drain_req_o | output | NL | Per-lane request to write back buffered results |
| beat_block_o | output | 1 | Refuse new memory beats |
| exc_valid_o | output | 1 | One-cycle exception response |
| exc_vstart_o | output | VW | vstart reported with the exception |
| burst_exc_o | output | 1 | The current burst faulted |

## Verification
The drain is driven with several grant patterns. Grants arrive one lane at a time, include a lane that was never requested, and finish all at once. Together these show whether the response waits for the last requested lane and whether stray grants are filtered out. A fault with empty queues checks the short path straight to the response. A repeated fault during a drain, with a new vstart and new occupancy, shows whether the snapshot is really frozen. Flushes are applied in mid-drain and together with a fault to separate flush priority from normal completion. `burst_start_i` is pulsed both during a drain and in idle to show when the replay flag may clear.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_AWAIT   = 2'd2,
    ST_RAISE   = 2'd3
  } ldf_state_e;
endpackage

// File: rtl/ldf_ctrl.sv
module ldf_ctrl
  import ldf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flush_i,
  input  logic       fault_i,
  input  logic       any_occ_i,
  input  logic       all_clear_i,
  output ldf_state_e state_o,
  output logic       capture_o
);
  ldf_state_e state_q, state_d;

  // a fault is only taken in idle, and a flush overrides it
  assign capture_o = (state_q == ST_IDLE) && fault_i && !flush_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (capture_o) state_d = any_occ_i ? ST_PRESENT : ST_RAISE;
      ST_PRESENT: state_d = ST_AWAIT;
      ST_AWAIT:   if (all_clear_i) state_d = ST_RAISE;
      ST_RAISE:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (flush_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ldf_lanes.sv
module ldf_lanes #(
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic          capture_i,
  input  logic          draining_i,
  input  logic [NL-1:0] occ_i,
  input  logic [NL-1:0] gnt_i,
  output logic [NL-1:0] pending_o,
  output logic          all_clear_o
);
  logic [NL-1:0] pend_q;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || flush_i)              pend_q[i] <= 1'b0;
      else if (capture_i)              pend_q[i] <= occ_i[i];
      else if (draining_i && gnt_i[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pending_o   = pend_q;
  assign all_clear_o = ~|(pend_q & ~gnt_i);
endmodule

// File: rtl/ldf_resp.sv
module ldf_resp #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic          capture_i,
  input  logic          idle_i,
  input  logic          burst_start_i,
  input  logic [VW-1:0] vstart_i,
  output logic [VW-1:0] vstart_o,
  output logic          burst_exc_o
);
  logic [VW-1:0] vs_q;
  logic          bx_q;

  always_ff @(posedge clk) begin
    if (rst)            vs_q <= '0;
    else if (capture_i) vs_q <= vstart_i;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i)              bx_q <= 1'b0;
    else if (capture_i)              bx_q <= 1'b1;
    else if (idle_i && burst_start_i) bx_q <= 1'b0;
  end

  assign vstart_o    = vs_q;
  assign burst_exc_o = bx_q;
endmodule

// File: rtl/ld_fault_drain.sv
module ld_fault_drain
  import ldf_pkg::*;
#(
  parameter int NL = 4,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic          fault_i,
  input  logic          burst_start_i,
  input  logic [VW-1:0] vstart_i,
  input  logic [NL-1:0] q_occ_i,
  input  logic [NL-1:0] lane_gnt_i,
  output logic [NL-1:0] drain_req_o,
  output logic          beat_block_o,
  output logic          exc_valid_o,
  output logic [VW-1:0] exc_vstart_o,
  output logic          burst_exc_o
);
  ldf_state_e    state;
  logic          capture, all_clear, draining;
  logic [NL-1:0] pending;

  ldf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .flush_i(flush_i), .fault_i(fault_i),
    .any_occ_i(|q_occ_i), .all_clear_i(all_clear),
    .state_o(state), .capture_o(capture)
  );

  assign draining = (state == ST_PRESENT) || (state == ST_AWAIT);

  ldf_lanes #(.NL(NL)) u_lanes (
    .clk(clk), .rst(rst), .flush_i(flush_i), .capture_i(capture),
    .draining_i(draining), .occ_i(q_occ_i), .gnt_i(lane_gnt_i),
    .pending_o(pending), .all_clear_o(all_clear)
  );

  ldf_resp #(.VW(VW)) u_resp (
    .clk(clk), .rst(rst), .flush_i(flush_i), .capture_i(capture),
    .idle_i(state == ST_IDLE), .burst_start_i(burst_start_i),
    .vstart_i(vstart_i), .vstart_o(exc_vstart_o), .burst_exc_o(burst_exc_o)
  );

  // outputs decode flop state only
  assign drain_req_o  = draining ? pending : '0;
  assign beat_block_o = (state != ST_IDLE);
  assign exc_valid_o  = (state == ST_RAISE);
endmodule

// File: rtl/ldf_chk.sv
module ldf_chk #(
  parameter int NL = 4,
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          flush_i,
  input logic          fault_i,
  input logic [NL-1:0] drain_req_o,
  input logic          beat_block_o,
  input logic          exc_valid_o,
  input logic [VW-1:0] exc_vstart_o,
  input logic          burst_exc_o
);
  // R5
  exc_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid_o |=> !exc_valid_o);
  // R7
  exc_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid_o |-> beat_block_o);
  // R4
  exc_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid_o |-> (drain_req_o == '0));
  // R4
  drain_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((|drain_req_o) && !flush_i) |=> ((drain_req_o & ~$past(drain_req_o)) == '0));
  // R9
  flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!beat_block_o && !exc_valid_o && (drain_req_o == '0) && !burst_exc_o));
  // R2
  fault_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!beat_block_o && fault_i && !flush_i) |=> (beat_block_o && burst_exc_o));
  // R6
  vstart_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_block_o && !flush_i) |=> $stable(exc_vstart_o));
endmodule

bind ld_fault_drain ldf_chk #(.NL(NL), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .flush_i(flush_i), .fault_i(fault_i),
  .drain_req_o(drain_req_o), .beat_block_o(beat_block_o),
  .exc_valid_o(exc_valid_o), .exc_vstart_o(exc_vstart_o),
  .burst_exc_o(burst_exc_o)
);

// File: tb/sim_ld_fault_drain.sv
`timescale 1ns/1ps
module sim_ld_fault_drain;
  localparam int NL = 4;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush_i = 1'b0, fault_i = 1'b0, burst_start_i = 1'b0;
  logic [VW-1:0] vstart_i = '0;
  logic [NL-1:0] q_occ_i = '0, lane_gnt_i = '0;
  logic [NL-1:0] drain_req_o;
  logic          beat_block_o, exc_valid_o, burst_exc_o;
  logic [VW-1:0] exc_vstart_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ld_fault_drain #(.NL(NL), .VW(VW)) u0 (
    .clk(clk), .rst(rst), .flush_i(flush_i), .fault_i(fault_i),
    .burst_start_i(burst_start_i), .vstart_i(vstart_i), .q_occ_i(q_occ_i),
    .lane_gnt_i(lane_gnt_i), .drain_req_o(drain_req_o),
    .beat_block_o(beat_block_o), .exc_valid_o(exc_valid_o),
    .exc_vstart_o(exc_vstart_o), .burst_exc_o(burst_exc_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flush_i = 0; fault_i = 0; burst_start_i = 0; q_occ_i = '0; lane_gnt_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 block", beat_block_o, 0);
    chk("R1 exc", exc_valid_o, 0);
    chk("R1 drain", drain_req_o, 0);
    chk("R1 burst", burst_exc_o, 0);
  endtask

  task automatic t_drain();
    fault_i = 1; q_occ_i = 4'b1011; vstart_i = 16'd37; tick();
    chk("R2 drain", drain_req_o, 4'b1011);
    chk("R2 block", beat_block_o, 1);
    chk("R2 exc", exc_valid_o, 0);
    chk("R8 burst set", burst_exc_o, 1);
    fault_i = 0; vstart_i = 16'd99; q_occ_i = 4'b1111; lane_gnt_i = 4'b0001; tick();
    chk("R4 lane0 cleared", drain_req_o, 4'b1010);
    chk("R12 no new lanes", drain_req_o & 4'b0100, 0);
    chk("R4 no early exc", exc_valid_o, 0);
    lane_gnt_i = 4'b0100; tick();
    chk("R12 stray grant", drain_req_o, 4'b1010);
    chk("R7 still blocked", beat_block_o, 1);
    lane_gnt_i = 4'b1010; tick();
    chk("R4 exc after last grant", exc_valid_o, 1);
    chk("R4 drain empty", drain_req_o, 0);
    chk("R6 vstart", exc_vstart_o, 16'd37);
    chk("R7 block on exc", beat_block_o, 1);
    lane_gnt_i = 0; q_occ_i = 0; tick();
    chk("R5 exc one cycle", exc_valid_o, 0);
    chk("R7 released", beat_block_o, 0);
    chk("R8 burst held", burst_exc_o, 1);
    burst_start_i = 1; tick(); burst_start_i = 0;
    chk("R8 burst cleared", burst_exc_o, 0);
  endtask

  task automatic t_fast_grant();
    fault_i = 1; q_occ_i = 4'b0011; vstart_i = 16'd7; tick();
    fault_i = 0; q_occ_i = 0; lane_gnt_i = 4'b0011; tick();
    chk("R4 all granted at once", drain_req_o, 0);
    chk("R4 not before second edge", exc_valid_o, 0);
    lane_gnt_i = 0; tick();
    chk("R4 exc after drain", exc_valid_o, 1);
    chk("R6 vstart fast", exc_vstart_o, 16'd7);
    tick(); burst_start_i = 1; tick(); burst_start_i = 0;
  endtask

  task automatic t_empty();
    fault_i = 1; q_occ_i = 0; vstart_i = 16'd5; tick();
    chk("R3 exc now", exc_valid_o, 1);
    chk("R3 vstart", exc_vstart_o, 16'd5);
    chk("R3 no drain", drain_req_o, 0);
    fault_i = 0; tick();
    chk("R5 exc drop", exc_valid_o, 0);
    chk("R5 idle", beat_block_o, 0);
    burst_start_i = 1; tick(); burst_start_i = 0;
  endtask

  task automatic t_refault();
    fault_i = 1; q_occ_i = 4'b0011; vstart_i = 16'd10; tick();
    fault_i = 1; q_occ_i = 4'b1100; vstart_i = 16'd20; tick();
    chk("R11 snapshot kept", drain_req_o, 4'b0011);
    lane_gnt_i = 4'b0011; tick();
    fault_i = 0; lane_gnt_i = 0; q_occ_i = 0;
    chk("R11 exc", exc_valid_o, 1);
    chk("R11 vstart not recaptured", exc_vstart_o, 16'd10);
    tick();
    chk("R11 single response", exc_valid_o, 0);
    tick();
    chk("R11 no second response", exc_valid_o, 0);
    burst_start_i = 1; tick(); burst_start_i = 0;
  endtask

  task automatic t_flush();
    fault_i = 1; q_occ_i = 4'b0110; vstart_i = 16'd3; tick();
    fault_i = 0; tick();
    flush_i = 1; tick(); flush_i = 0;
    chk("R9 block", beat_block_o, 0);
    chk("R9 drain", drain_req_o, 0);
    chk("R9 burst", burst_exc_o, 0);
    chk("R9 exc", exc_valid_o, 0);
    lane_gnt_i = 4'b0110; tick(); lane_gnt_i = 0; tick();
    chk("R9 no late exc", exc_valid_o, 0);
  endtask

  task automatic t_flush_fault();
    flush_i = 1; fault_i = 1; q_occ_i = 4'b0001; tick();
    flush_i = 0; fault_i = 0; q_occ_i = 0;
    chk("R10 block", beat_block_o, 0);
    chk("R10 burst", burst_exc_o, 0);
    chk("R10 drain", drain_req_o, 0);
    tick();
    chk("R10 exc", exc_valid_o, 0);
  endtask

  task automatic t_burst_during_drain();
    fault_i = 1; q_occ_i = 4'b0001; tick();
    fault_i = 0; q_occ_i = 0; burst_start_i = 1; tick();
    chk("R8 ignored while draining", burst_exc_o, 1);
    burst_start_i = 0; lane_gnt_i = 4'b0001; tick(); lane_gnt_i = 0;
    chk("R8 exc", exc_valid_o, 1);
    tick();
    chk("R8 kept after response", burst_exc_o, 1);
    burst_start_i = 1; tick(); burst_start_i = 0;
    chk("R8 cleared in idle", burst_exc_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle_inputs();
    repeat (3) tick();
    t_reset();
    rst = 0; tick();
    t_reset();
    t_drain();
    t_fast_grant();
    t_empty();
    t_refault();
    t_flush();
    t_flush_fault();
    t_burst_during_drain();
    repeat (2) tick();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule